// File: doc/BRIEF.md
# Transport-Layer Frame Deassembler for a Multi-Lane Sample Receiver

This block sits behind the link layer of a high-speed serial receiver that feeds one or two DACs. Every octet clock it takes one octet from each of eight lanes. The octets arrive already aligned and descrambled. The block groups them into frames of F octets per lane and rebuilds the sample words that the frame carries. An eleven-entry mode code selects the lane/frame layout. The layouts cover several cases: 16-bit samples split high-density across two lanes, whole 16-bit samples over two or four octets, 12-bit samples packed nibble by nibble into three-octet frames, and 8-bit or 16-bit real samples.

A start-of-frame pulse, raised together with octet 0 of a frame, aligns the internal octet counter. When the last octet of a frame has been taken, the rebuilt words appear on eight 16-bit output slots. They come with a one-cycle frame-valid strobe. A mode code outside the table raises an error flag and suppresses the strobe.

Top module: `jrx_frame_deasm`

## Requirements
- R1: While `rst_n` is low at a clock edge, `frame_valid_o`, `mode_err_o` and every bit of `smp_o` read zero after that edge.
- R2: Octet 0 of a frame is the one presented together with `sof_i`. For a mode of F octets per lane, `frame_valid_o` is high for exactly the one cycle after the edge that takes octet F-1, and it stays low in between. No strobe occurs before the first `sof_i` after reset.
- R3: A `sof_i` pulse in the middle of a frame discards the partial frame and restarts the octet count at 0.
- R4: Slot j of `smp_o` is bits [16j+15:16j]. On every lane the first octet of a frame is the most significant, and 12-bit samples are rebuilt MSB-first across octet boundaries.
- R5: Mode code 0 (L8 M2 F1 S2, high density): slot0 = {lane0,lane1} (I, time 0), slot1 = {lane4,lane5} (Q, time 0), slot2 = {lane2,lane3} (I, time 1), slot3 = {lane6,lane7} (Q, time 1).
- R6: Mode codes 1 (L4 M2 F1 S1) and 10 (real, L4 M1 F1 S2): slot0 = {lane0,lane1} and slot1 = {lane2,lane3}. Code 2 (L8 M4 F1 S1) adds second-DAC slot4 = {lane4,lane5} and slot5 = {lane6,lane7}.
- R7: Mode code 3 (L2 M2 F2): slot0 = lane0 octets {0,1}, slot1 = lane1 octets {0,1}. Code 4 (L4 M4 F2) adds slot4 from lane2 and slot5 from lane3.
- R8: Mode code 5 (L1 M2 F4): slot0 = lane0 octets {0,1} (I), slot1 = lane0 octets {2,3} (Q).
- R9: Mode codes 6 (L2 M4 F3, 12-bit) and 7 (L4 M8 F3, 12-bit): lane k carries I in its first 12 bits and Q in the next 12. Slot 2k = I and slot 2k+1 = Q, for k < 2 in code 6 and k < 4 in code 7. Each sample is left-justified with the low 4 bits zero.
- R10: Mode code 8 (real, L4 M1 F3 S8, 12-bit): lane k yields real samples 2k and 2k+1 on slots 2k and 2k+1, each left-justified with the low nibble zero.
- R11: Mode code 9 (real, L8 M1 F1 S8, 8-bit): slot k = {lane k octet, 8'h00}.
- R12: Slots that a mode does not use read zero at its strobe.
- R13: Mode codes 11 to 15 set `mode_err_o` one cycle later and keep `frame_valid_o` low. `smp_o` keeps its previous value. The flag clears one cycle after a valid code returns.
- R14: `smp_o` changes only on the cycle in which `frame_valid_o` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Frame layout code (0..10 valid) |
| sof_i | input | 1 | High with octet 0 of a frame |
| lane_oct_i | input | 64 | Lane k octet at bits [8k+7:8k] |
| frame_valid_o | output | 1 | One-cycle strobe: slots hold a new frame |
| mode_err_o | output | 1 | Mode code is outside the table |
| smp_o | output | 128 | Eight 16-bit sample slots |

## Verification
The assertions take for granted that `mode_i` stays constant from octet 0 of a frame until the strobe that ends it. They also assume that `sof_i` is only raised on the octet meant as octet 0. Given those two conditions, the strobe timing and the zero padding can be tied to the code sampled one cycle earlier. The stimulus changes the code only in the same cycle as a `sof_i` pulse, and it holds reset for several cycles before releasing it. Random frames, drawn from a fixed seed, cover all eleven codes with random octets. Directed runs cover the unaligned start, a re-alignment in the middle of a four-octet frame, and a stretch with an unknown code.

// File: rtl/jrx_pkg.sv
// Shared constants, mode codes and mode decode functions for the frame
// deassembler. Assumes 8-bit octets, 16-bit output slots and eight lanes.
package jrx_pkg;
    localparam int OCT_W     = 8;
    localparam int SMP_W     = 16;
    localparam int NUM_LANES = 8;
    localparam int NUM_SLOTS = 8;
    localparam int MODE_W    = 4;
    localparam int L0_OCT    = 4;                 // deepest frame (lane 0 only)
    localparam int MID_OCT   = 3;                 // deepest frame on lanes 1..3
    localparam int L0_FW     = L0_OCT * OCT_W;
    localparam int MID_FW    = MID_OCT * OCT_W;
    localparam int CNT_W     = $clog2(L0_OCT);

    typedef enum logic [MODE_W-1:0] {
        MD_HD16_IQ2T     = 4'd0,
        MD_HD16_IQ1      = 4'd1,
        MD_HD16_IQ1_DUAL = 4'd2,
        MD_W16_IQ1       = 4'd3,
        MD_W16_IQ1_DUAL  = 4'd4,
        MD_W16_IQ1_SOLO  = 4'd5,
        MD_N12_DUC2      = 4'd6,
        MD_N12_DUC2_DUAL = 4'd7,
        MD_N12_REAL8     = 4'd8,
        MD_N8_REAL8      = 4'd9,
        MD_HD16_REAL2    = 4'd10
    } mode_e;

    // True when the code names a supported layout.
    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        return (m <= MD_HD16_REAL2);
    endfunction

    // Index of the last octet of a frame (F-1) for the code.
    function automatic logic [CNT_W-1:0] last_octet(input logic [MODE_W-1:0] m);
        case (m)
            MD_W16_IQ1, MD_W16_IQ1_DUAL:                 return CNT_W'(1);
            MD_N12_DUC2, MD_N12_DUC2_DUAL, MD_N12_REAL8: return CNT_W'(2);
            MD_W16_IQ1_SOLO:                             return CNT_W'(3);
            default:                                     return CNT_W'(0);
        endcase
    endfunction
endpackage

// File: rtl/jrx_frame_ctr.sv
// Octet-in-frame counter. It restarts at 0 on sof_i and wraps after the
// index last_idx_i. It flags the final octet once the first sof_i has been
// seen. Assumes last_idx_i is steady within a frame.
module jrx_frame_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic [CNT_W-1:0] last_idx_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             locked_q;
    logic [CNT_W-1:0] idx;

    // Index of the octet being presented this cycle.
    assign idx    = sof_i ? '0 : cnt_q;
    assign last_o = (sof_i || locked_q) && (idx == last_idx_i);

    // Advance the count and remember that alignment has happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            if (sof_i) locked_q <= 1'b1;
            cnt_q <= (idx == last_idx_i) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/jrx_lane_gather.sv
// Per-lane octet history. frame_o holds the last DEPTH octets, the current
// one included, with the oldest in the top byte. Assumes DEPTH >= 2.
module jrx_lane_gather #(
    parameter int OCT_W = 8,
    parameter int DEPTH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OCT_W-1:0]       oct_i,
    output logic [DEPTH*OCT_W-1:0] frame_o
);
    localparam int HIST_W = (DEPTH - 1) * OCT_W;

    logic [HIST_W-1:0] hist_q;

    assign frame_o = {hist_q, oct_i};

    // Shift the current octet into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= frame_o[HIST_W-1:0];
    end
endmodule

// File: rtl/jrx_sample_unpack.sv
// Combinational slot builder. It maps the per-lane frame views onto eight
// 16-bit slots for the selected mode, left-justifies 12-bit and 8-bit samples
// and zeroes unused slots. Assumes each frame view ends with octet F-1 in its
// low byte.
module jrx_sample_unpack
    import jrx_pkg::*;
(
    input  logic [MODE_W-1:0]          mode_i,
    input  logic [L0_FW-1:0]           f0_i,
    input  logic [3*MID_FW-1:0]        fmid_i,
    input  logic [4*OCT_W-1:0]         fhi_i,
    output logic [NUM_SLOTS*SMP_W-1:0] smp_o
);
    logic [MID_FW-1:0] lf [4];
    logic [OCT_W-1:0]  ob [NUM_LANES];
    logic [SMP_W-1:0]  s  [NUM_SLOTS];

    function automatic logic [SMP_W-1:0] pad12(input logic [11:0] v);
        return {v, {(SMP_W-12){1'b0}}};
    endfunction

    // Gather the three-octet view and newest octet of every lane.
    always_comb begin
        lf[0] = f0_i[MID_FW-1:0];
        for (int k = 1; k < 4; k++) lf[k] = fmid_i[(k-1)*MID_FW +: MID_FW];
        for (int k = 0; k < 4; k++) ob[k] = lf[k][OCT_W-1:0];
        for (int k = 4; k < NUM_LANES; k++) ob[k] = fhi_i[(k-4)*OCT_W +: OCT_W];
    end

    // Place samples into slots according to the mode.
    always_comb begin
        for (int j = 0; j < NUM_SLOTS; j++) s[j] = '0;
        case (mode_i)
            MD_HD16_IQ2T: begin
                s[0] = {ob[0], ob[1]};
                s[1] = {ob[4], ob[5]};
                s[2] = {ob[2], ob[3]};
                s[3] = {ob[6], ob[7]};
            end
            MD_HD16_IQ1, MD_HD16_REAL2: begin
                s[0] = {ob[0], ob[1]};
                s[1] = {ob[2], ob[3]};
            end
            MD_HD16_IQ1_DUAL: begin
                s[0] = {ob[0], ob[1]};
                s[1] = {ob[2], ob[3]};
                s[4] = {ob[4], ob[5]};
                s[5] = {ob[6], ob[7]};
            end
            MD_W16_IQ1: begin
                s[0] = lf[0][SMP_W-1:0];
                s[1] = lf[1][SMP_W-1:0];
            end
            MD_W16_IQ1_DUAL: begin
                s[0] = lf[0][SMP_W-1:0];
                s[1] = lf[1][SMP_W-1:0];
                s[4] = lf[2][SMP_W-1:0];
                s[5] = lf[3][SMP_W-1:0];
            end
            MD_W16_IQ1_SOLO: begin
                s[0] = f0_i[L0_FW-1 -: SMP_W];
                s[1] = f0_i[SMP_W-1:0];
            end
            MD_N12_DUC2: begin
                for (int k = 0; k < 2; k++) begin
                    s[2*k]   = pad12(lf[k][23:12]);
                    s[2*k+1] = pad12(lf[k][11:0]);
                end
            end
            MD_N12_DUC2_DUAL, MD_N12_REAL8: begin
                for (int k = 0; k < 4; k++) begin
                    s[2*k]   = pad12(lf[k][23:12]);
                    s[2*k+1] = pad12(lf[k][11:0]);
                end
            end
            MD_N8_REAL8: begin
                for (int k = 0; k < NUM_LANES; k++) s[k] = {ob[k], {(SMP_W-OCT_W){1'b0}}};
            end
            default: ;
        endcase
    end

    // Flatten the slots onto the output bus.
    always_comb begin
        for (int j = 0; j < NUM_SLOTS; j++) smp_o[j*SMP_W +: SMP_W] = s[j];
    end
endmodule

// File: rtl/jrx_frame_deasm.sv
// Frame deassembler top. It collects octets per lane, counts octets within a
// frame and registers the rebuilt slots with a one-cycle strobe at frame end.
// Lane 0 keeps four octets, lanes 1..3 keep three and lanes 4..7 only ever
// carry single-octet frames. Assumes aligned, descrambled lanes and a mode
// that is steady within a frame.
module jrx_frame_deasm
    import jrx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [MODE_W-1:0]             mode_i,
    input  logic                          sof_i,
    input  logic [NUM_LANES*OCT_W-1:0]    lane_oct_i,
    output logic                          frame_valid_o,
    output logic                          mode_err_o,
    output logic [NUM_SLOTS*SMP_W-1:0]    smp_o
);
    logic                          mode_ok;
    logic [CNT_W-1:0]              last_idx;
    logic                          frame_end;
    logic [L0_FW-1:0]              f0;
    logic [3*MID_FW-1:0]           fmid;
    logic [4*OCT_W-1:0]            fhi;
    logic [NUM_SLOTS*SMP_W-1:0]    smp_next;
    logic [NUM_SLOTS*SMP_W-1:0]    smp_q;
    logic                          fv_q;
    logic                          err_q;

    assign mode_ok  = mode_known(mode_i);
    assign last_idx = last_octet(mode_i);

    jrx_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_i      (sof_i),
        .last_idx_i (last_idx),
        .last_o     (frame_end)
    );

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        if (k == 0) begin : g_deep
            jrx_lane_gather #(.OCT_W(OCT_W), .DEPTH(L0_OCT)) u_gather (
                .clk     (clk),
                .rst_n   (rst_n),
                .oct_i   (lane_oct_i[k*OCT_W +: OCT_W]),
                .frame_o (f0)
            );
        end else if (k < 4) begin : g_mid
            jrx_lane_gather #(.OCT_W(OCT_W), .DEPTH(MID_OCT)) u_gather (
                .clk     (clk),
                .rst_n   (rst_n),
                .oct_i   (lane_oct_i[k*OCT_W +: OCT_W]),
                .frame_o (fmid[(k-1)*MID_FW +: MID_FW])
            );
        end else begin : g_flat
            assign fhi[(k-4)*OCT_W +: OCT_W] = lane_oct_i[k*OCT_W +: OCT_W];
        end
    end

    jrx_sample_unpack u_unpack (
        .mode_i (mode_i),
        .f0_i   (f0),
        .fmid_i (fmid),
        .fhi_i  (fhi),
        .smp_o  (smp_next)
    );

    // Register the slots, the frame strobe and the mode error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
            fv_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            fv_q  <= frame_end && mode_ok;
            err_q <= !mode_ok;
            if (frame_end && mode_ok) smp_q <= smp_next;
        end
    end

    assign frame_valid_o = fv_q;
    assign mode_err_o    = err_q;
    assign smp_o         = smp_q;
endmodule

// File: rtl/jrx_deasm_chk.sv
// Assertion checker for the frame deassembler, bound to the top module.
// Assumes mode_i is steady from octet 0 to the strobe of each frame.
module jrx_deasm_chk
    import jrx_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic [MODE_W-1:0]          mode_i,
    input logic                       sof_i,
    input logic                       frame_valid_o,
    input logic                       mode_err_o,
    input logic [NUM_SLOTS*SMP_W-1:0] smp_o
);
    function automatic logic one_octet(input logic [MODE_W-1:0] m);
        return mode_known(m) && (last_octet(m) == '0);
    endfunction

    function automatic logic narrow_mode(input logic [MODE_W-1:0] m);
        return (m == MD_HD16_IQ1) || (m == MD_W16_IQ1) ||
               (m == MD_W16_IQ1_SOLO) || (m == MD_HD16_REAL2);
    endfunction

    function automatic logic low_clear(input logic [NUM_SLOTS*SMP_W-1:0] v, input int nb);
        logic acc = 1'b1;
        for (int j = 0; j < NUM_SLOTS; j++)
            for (int b = 0; b < nb; b++)
                if (v[j*SMP_W + b]) acc = 1'b0;
        return acc;
    endfunction

    AST_BAD_MODE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_known(mode_i) |=> (mode_err_o && !frame_valid_o)); // R13
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> ($past(rst_n) && !mode_known($past(mode_i)))); // R13
    AST_SINGLE_OCTET_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sof_i) && one_octet($past(mode_i))) |-> frame_valid_o); // R2
    AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_i && mode_known(mode_i) && !one_octet(mode_i)) |=> !frame_valid_o); // R2
    AST_SLOTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !frame_valid_o) |-> $stable(smp_o)); // R14
    AST_UNUSED_SLOTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && frame_valid_o && narrow_mode($past(mode_i)))
        |-> (smp_o[NUM_SLOTS*SMP_W-1:2*SMP_W] == '0)); // R12
    AST_REAL8_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && frame_valid_o && ($past(mode_i) == MD_N8_REAL8))
        |-> low_clear(smp_o, 8)); // R11
    AST_N12_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && frame_valid_o && (($past(mode_i) == MD_N12_DUC2) ||
         ($past(mode_i) == MD_N12_DUC2_DUAL) || ($past(mode_i) == MD_N12_REAL8)))
        |-> low_clear(smp_o, 4)); // R9
endmodule

bind jrx_frame_deasm jrx_deasm_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .sof_i         (sof_i),
    .frame_valid_o (frame_valid_o),
    .mode_err_o    (mode_err_o),
    .smp_o         (smp_o)
);

// File: tb/sim_jrx_frame_deasm.sv
`timescale 1ns/1ps
module sim_jrx_frame_deasm;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [3:0]   mode_i;
    logic         sof_i;
    logic [63:0]  lane_oct_i;
    logic         frame_valid_o;
    logic         mode_err_o;
    logic [127:0] smp_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [7:0] oc [8][4];

    always #4 clk = ~clk;

    jrx_frame_deasm u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .sof_i         (sof_i),
        .lane_oct_i    (lane_oct_i),
        .frame_valid_o (frame_valid_o),
        .mode_err_o    (mode_err_o),
        .smp_o         (smp_o)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int flen(input int m);
        case (m)
            3, 4:    return 2;
            5:       return 4;
            6, 7, 8: return 3;
            default: return 1;
        endcase
    endfunction

    function automatic string req_of(input int m);
        case (m)
            0:        return "R5";
            1, 2, 10: return "R6";
            3, 4:     return "R7";
            5:        return "R8";
            6, 7:     return "R9";
            8:        return "R10";
            default:  return "R11";
        endcase
    endfunction

    function automatic logic [15:0] hd(input int l);
        return {oc[l][0], oc[l+1][0]};
    endfunction
    function automatic logic [15:0] wd(input int l, input int o);
        return {oc[l][o], oc[l][o+1]};
    endfunction
    function automatic logic [15:0] n12a(input int l);
        return {oc[l][0], oc[l][1][7:4], 4'h0};
    endfunction
    function automatic logic [15:0] n12b(input int l);
        return {oc[l][1][3:0], oc[l][2], 4'h0};
    endfunction

    // Expected slots from the requirements (unused slots zero, R12).
    function automatic logic [127:0] model(input int m);
        logic [15:0] e [8];
        logic [127:0] r;
        for (int j = 0; j < 8; j++) e[j] = 16'h0;
        case (m)
            0: begin e[0] = hd(0); e[1] = hd(4); e[2] = hd(2); e[3] = hd(6); end
            1, 10: begin e[0] = hd(0); e[1] = hd(2); end
            2: begin e[0] = hd(0); e[1] = hd(2); e[4] = hd(4); e[5] = hd(6); end
            3: begin e[0] = wd(0, 0); e[1] = wd(1, 0); end
            4: begin e[0] = wd(0, 0); e[1] = wd(1, 0); e[4] = wd(2, 0); e[5] = wd(3, 0); end
            5: begin e[0] = wd(0, 0); e[1] = wd(0, 2); end
            6: for (int k = 0; k < 2; k++) begin e[2*k] = n12a(k); e[2*k+1] = n12b(k); end
            7, 8: for (int k = 0; k < 4; k++) begin e[2*k] = n12a(k); e[2*k+1] = n12b(k); end
            9: for (int k = 0; k < 8; k++) e[k] = {oc[k][0], 8'h00};
            default: ;
        endcase
        for (int j = 0; j < 8; j++) r[j*16 +: 16] = e[j];
        return r;
    endfunction

    // Send one aligned frame in mode m and check strobe, slots and hold.
    task automatic run_frame(input int m);
        int f = flen(m);
        logic [127:0] exp;
        for (int l = 0; l < 8; l++)
            for (int o = 0; o < 4; o++) oc[l][o] = 8'($urandom);
        for (int o = 0; o < f; o++) begin
            @(negedge clk);
            if (o > 0) check("R2 no strobe mid-frame", {127'h0, frame_valid_o}, 128'h0);
            mode_i = 4'(m);
            sof_i  = (o == 0);
            for (int l = 0; l < 8; l++) lane_oct_i[l*8 +: 8] = oc[l][o];
        end
        @(negedge clk);
        exp = model(m);
        check("R2 strobe after last octet", {127'h0, frame_valid_o}, 128'h1);
        check(req_of(m), smp_o, exp);
        sof_i      = 1'b0;
        lane_oct_i = {$urandom, $urandom};
        if (f > 1) begin
            @(negedge clk);
            check("R14 strobe low after frame", {127'h0, frame_valid_o}, 128'h0);
            check("R14 slots held", smp_o, exp);
        end
    endtask

    initial begin
        logic [127:0] prev;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; sof_i = 1'b0; mode_i = 4'd0; lane_oct_i = '0;
        repeat (4) @(negedge clk);
        check("R1 strobe in reset", {127'h0, frame_valid_o}, 128'h0);
        check("R1 error in reset", {127'h0, mode_err_o}, 128'h0);
        check("R1 slots in reset", smp_o, 128'h0);
        rst_n = 1'b1;

        // R2: no strobe before the first start-of-frame.
        mode_i = 4'd9;
        for (int c = 0; c < 6; c++) begin
            lane_oct_i = {$urandom, $urandom};
            @(negedge clk);
            check("R2 no strobe before alignment", {127'h0, frame_valid_o}, 128'h0);
        end

        // Every mode once, directed; R4 ordering is covered by each.
        for (int m = 0; m <= 10; m++) run_frame(m);

        // R3: abort a four-octet frame after two octets, then realign.
        @(negedge clk);
        mode_i = 4'd5; sof_i = 1'b1; lane_oct_i = {$urandom, $urandom};
        @(negedge clk);
        sof_i = 1'b0; lane_oct_i = {$urandom, $urandom};
        run_frame(5);
        check("R3 realigned frame slots", smp_o, model(5));

        // R13: unknown code flags an error, no strobe, slots held.
        @(negedge clk);
        prev = smp_o;
        mode_i = 4'd12; sof_i = 1'b1; lane_oct_i = {$urandom, $urandom};
        @(negedge clk);
        sof_i = 1'b0;
        check("R13 error raised", {127'h0, mode_err_o}, 128'h1);
        for (int c = 0; c < 3; c++) begin
            lane_oct_i = {$urandom, $urandom};
            @(negedge clk);
            check("R13 no strobe on bad code", {127'h0, frame_valid_o}, 128'h0);
            check("R13 slots unchanged", smp_o, prev);
        end
        run_frame(3);
        check("R13 error cleared", {127'h0, mode_err_o}, 128'h0);

        // Random frames across all codes.
        for (int i = 0; i < 300; i++) run_frame(int'($urandom_range(0, 10)));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule